// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block converts a segment value and an offset into a linear address. It serves two addressing modes with one datapath. In real mode it shifts a 16-bit segment value left by one hex digit and adds a 16-bit offset, giving a 20-bit address that wraps within one megabyte. In protected mode it takes the fields of a descriptor that has already been fetched and cached upstream: a 32-bit base, a 20-bit limit, a granularity flag, a descriptor privilege level and a present flag. It adds a 32-bit offset to the base. It also checks the offset against the scaled limit and the caller's requested privilege against the descriptor's level.

A request strobe starts a translation. One cycle later the block produces one of two results. The first is a linear address with a one-cycle valid pulse. The second is a one-cycle, 2-bit fault code, with valid held low. A small state machine sequences this. The states are `ST_IDLE` (nothing to report), `ST_GRANT` (address valid) and `ST_FAULT` (fault code shown). Every state moves on each clock edge. A request with no fault goes to `ST_GRANT`. A request with any fault goes to `ST_FAULT`. No request goes to `ST_IDLE`.

Top module: `seg_xlate`

## Requirements
- R1: In real mode (`prot_mode`=0), the address is ((seg_val << 4) + offset[15:0]) modulo 2^20. Bits 31:20 of `lin_addr` are zero, and offset bits 31:16 have no effect.
- R2: In real mode, no fault is ever raised, and the descriptor fields and `rpl` have no effect on the result.
- R3: In protected mode, when no fault is raised, `lin_addr` = (desc_base + offset) modulo 2^32.
- R4: With `desc_gran`=0, the effective limit is the 20-bit limit zero-extended to 32 bits and used as a byte limit.
- R5: With `desc_gran`=1, the effective limit is {desc_limit, 12'hFFF}. For example, limit 001FFh allows offsets up to 001FFFFFh.
- R6: The comparison is unsigned over the full 32-bit offset. An offset equal to the effective limit is allowed. An offset greater than it gives fault code 2'b01 (limit).
- R7: Privilege level 0 is the most privileged. `rpl` greater than `desc_dpl` gives fault code 2'b10 (privilege). An equal or smaller `rpl` passes.
- R8: `desc_present`=0 in protected mode gives fault code 2'b11 (absent). When several faults apply at once, the order is absent, then privilege, then limit. Code 2'b00 means no fault.
- R9: The result appears exactly one cycle after the request. `valid` is a one-cycle pulse and is never high together with a nonzero fault code. On a fault, `lin_addr` reads zero.
- R10: After reset, `valid` is 0, `fault_code` is 2'b00 and `lin_addr` is 0.
- R11: A cycle without a request makes `valid` 0 and `fault_code` 2'b00 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Translation request strobe |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| seg_val | input | 16 | Segment value (real mode) |
| offset | input | 32 | Offset; real mode uses bits 15:0 |
| desc_base | input | 32 | Cached descriptor base |
| desc_limit | input | 20 | Cached descriptor limit |
| desc_gran | input | 1 | Granularity: 1 = 4 KiB units |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_present | input | 1 | Descriptor present flag |
| rpl | input | 2 | Requested privilege level |
| lin_addr | output | 32 | Linear address result |
| valid | output | 1 | One-cycle pulse: address valid |
| fault_code | output | 2 | 00 none, 01 limit, 10 privilege, 11 absent |

## Verification
The limit check and the privilege check run in parallel on the same request, and a not-present descriptor can arrive in that same cycle. The bench provokes this with descriptors that break two or three rules at once. Examples are an offset beyond the scaled limit together with an `rpl` above `desc_dpl`, and the same pair with `desc_present` low. The single code reported must then follow the fixed order: absent, then privilege, then limit. Random descriptors and offsets drawn near the limit mix these cases further, and every result is judged against a bench model of the rules.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_LIMIT  = 2'b01,
        FLT_PRIV   = 2'b10,
        FLT_ABSENT = 2'b11
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_GRANT = 2'b01,
        ST_FAULT = 2'b10
    } xl_state_e;

endpackage

// File: rtl/seg_real_addr.sv
// Shift-and-add address former used in real mode.
module seg_real_addr #(
    parameter int SEG_W   = 16,
    parameter int SHIFT   = 4,
    parameter int OUT_W   = 32
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [SEG_W-1:0] off,
    output logic [OUT_W-1:0] addr
);
    localparam int RA_W = SEG_W + SHIFT;

    logic [RA_W-1:0] base_shifted;
    logic [RA_W-1:0] sum;

    always_comb begin
        base_shifted = {seg, {SHIFT{1'b0}}};
        // carry beyond the real-address width is dropped
        sum  = base_shifted + RA_W'(off);
        addr = OUT_W'(sum);
    end
endmodule

// File: rtl/seg_limit_chk.sv
// Scales the limit by granularity and compares the offset against it.
module seg_limit_chk #(
    parameter int OFF_W      = 32,
    parameter int LIM_W      = 20,
    parameter int GRAN_SHIFT = 12
) (
    input  logic [OFF_W-1:0] off,
    input  logic [LIM_W-1:0] limit,
    input  logic             gran,
    output logic             over
);
    localparam int EXT_W = LIM_W + GRAN_SHIFT;

    logic [EXT_W-1:0] scaled;
    logic [OFF_W-1:0] eff_limit;

    always_comb begin
        scaled    = {limit, {GRAN_SHIFT{1'b1}}};
        eff_limit = gran ? OFF_W'(scaled) : OFF_W'(limit);
        over      = (off > eff_limit);
    end
endmodule

// File: rtl/seg_priv_chk.sv
// Requested level must be numerically no greater than the descriptor level.
module seg_priv_chk #(
    parameter int PL_W = 2
) (
    input  logic [PL_W-1:0] req_pl,
    input  logic [PL_W-1:0] desc_pl,
    output logic            deny
);
    always_comb deny = (req_pl > desc_pl);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W      = 16,
    parameter int OFF_W      = 32,
    parameter int LIM_W      = 20,
    parameter int GRAN_SHIFT = 12,
    parameter int PL_W       = 2,
    parameter int SEG_SHIFT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             prot_mode,
    input  logic [SEG_W-1:0] seg_val,
    input  logic [OFF_W-1:0] offset,
    input  logic [OFF_W-1:0] desc_base,
    input  logic [LIM_W-1:0] desc_limit,
    input  logic             desc_gran,
    input  logic [PL_W-1:0]  desc_dpl,
    input  logic             desc_present,
    input  logic [PL_W-1:0]  rpl,
    output logic [OFF_W-1:0] lin_addr,
    output logic             valid,
    output logic [1:0]       fault_code
);
    xl_state_e        state_q, state_d;
    logic [OFF_W-1:0] real_addr, prot_addr, addr_sel;
    logic             lim_over, priv_deny;
    fault_e           fault_d;
    fault_e           fault_q;
    logic [OFF_W-1:0] addr_q;

    seg_real_addr #(.SEG_W(SEG_W), .SHIFT(SEG_SHIFT), .OUT_W(OFF_W)) u_real (
        .seg  (seg_val),
        .off  (offset[SEG_W-1:0]),
        .addr (real_addr)
    );

    seg_limit_chk #(.OFF_W(OFF_W), .LIM_W(LIM_W), .GRAN_SHIFT(GRAN_SHIFT)) u_lim (
        .off   (offset),
        .limit (desc_limit),
        .gran  (desc_gran),
        .over  (lim_over)
    );

    seg_priv_chk #(.PL_W(PL_W)) u_priv (
        .req_pl  (rpl),
        .desc_pl (desc_dpl),
        .deny    (priv_deny)
    );

    // fault priority: absent, privilege, limit
    always_comb begin
        prot_addr = desc_base + offset;
        fault_d   = FLT_NONE;
        if (prot_mode) begin
            if (!desc_present)  fault_d = FLT_ABSENT;
            else if (priv_deny) fault_d = FLT_PRIV;
            else if (lim_over)  fault_d = FLT_LIMIT;
        end
        addr_sel = prot_mode ? prot_addr : real_addr;
    end

    // next-state selection
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_FAULT: begin
                if (req) state_d = (fault_d == FLT_NONE) ? ST_GRANT : ST_FAULT;
                else     state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            fault_q <= FLT_NONE;
        end else begin
            unique case (state_d)
                ST_GRANT: begin
                    addr_q  <= addr_sel;
                    fault_q <= FLT_NONE;
                end
                ST_FAULT: begin
                    addr_q  <= '0;
                    fault_q <= fault_d;
                end
                default: begin
                    fault_q <= FLT_NONE;
                end
            endcase
        end
    end

    assign lin_addr   = addr_q;
    assign valid      = (state_q == ST_GRANT);
    assign fault_code = fault_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 32,
    parameter int LIM_W = 20,
    parameter int PL_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             prot_mode,
    input logic [SEG_W-1:0] seg_val,
    input logic [OFF_W-1:0] offset,
    input logic [LIM_W-1:0] desc_limit,
    input logic             desc_present,
    input logic [PL_W-1:0]  rpl,
    input logic [PL_W-1:0]  desc_dpl,
    input logic [OFF_W-1:0] lin_addr,
    input logic             valid,
    input logic [1:0]       fault_code
);
    // R9
    valid_excl_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (fault_code == 2'b00));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!valid && fault_code == 2'b00));

    // R2
    real_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !prot_mode) |=> (valid && fault_code == 2'b00));

    // R1
    real_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !prot_mode) |=> (lin_addr[OFF_W-1:SEG_W+4] == '0));

    // R8
    absent_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && prot_mode && !desc_present) |=> (fault_code == 2'b11 && !valid));

    // R7
    priv_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && prot_mode && desc_present && (rpl > desc_dpl)) |=> (fault_code == 2'b10));

    // R9
    fault_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code != 2'b00) |-> (lin_addr == '0));
endmodule

bind seg_xlate seg_xlate_chk #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .LIM_W(LIM_W), .PL_W(PL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .prot_mode    (prot_mode),
    .seg_val      (seg_val),
    .offset       (offset),
    .desc_limit   (desc_limit),
    .desc_present (desc_present),
    .rpl          (rpl),
    .desc_dpl     (desc_dpl),
    .lin_addr     (lin_addr),
    .valid        (valid),
    .fault_code   (fault_code)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        prot_mode = 1'b0;
    logic [15:0] seg_val = '0;
    logic [31:0] offset = '0;
    logic [31:0] desc_base = '0;
    logic [19:0] desc_limit = '0;
    logic        desc_gran = 1'b0;
    logic [1:0]  desc_dpl = '0;
    logic        desc_present = 1'b0;
    logic [1:0]  rpl = '0;
    logic [31:0] lin_addr;
    logic        valid;
    logic [1:0]  fault_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    seg_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .prot_mode(prot_mode),
        .seg_val(seg_val), .offset(offset), .desc_base(desc_base),
        .desc_limit(desc_limit), .desc_gran(desc_gran), .desc_dpl(desc_dpl),
        .desc_present(desc_present), .rpl(rpl),
        .lin_addr(lin_addr), .valid(valid), .fault_code(fault_code)
    );

    function automatic logic [1:0] model_fault(input logic pm, input logic pres,
            input logic [1:0] rp, input logic [1:0] dp, input logic g,
            input logic [19:0] lim, input logic [31:0] off);
        logic [31:0] eff;
        eff = g ? {lim, 12'hFFF} : {12'h000, lim};
        if (!pm)        return 2'b00;
        if (!pres)      return 2'b11;
        if (rp > dp)    return 2'b10;
        if (off > eff)  return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [31:0] model_addr(input logic pm, input logic [15:0] sg,
            input logic [31:0] off, input logic [31:0] base);
        logic [19:0] r;
        r = {sg, 4'h0} + {4'h0, off[15:0]};
        return pm ? base + off : {12'h000, r};
    endfunction

    task automatic report(input string tag, input logic ok, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // drive at negedge, judge at next negedge (one register stage)
    task automatic xlate(input string tag, input logic pm, input logic [15:0] sg,
            input logic [31:0] off, input logic [31:0] base, input logic [19:0] lim,
            input logic g, input logic [1:0] dp, input logic pres, input logic [1:0] rp);
        logic [1:0]  ef;
        logic [31:0] ea;
        req = 1'b1; prot_mode = pm; seg_val = sg; offset = off; desc_base = base;
        desc_limit = lim; desc_gran = g; desc_dpl = dp; desc_present = pres; rpl = rp;
        ef = model_fault(pm, pres, rp, dp, g, lim, off);
        ea = (ef == 2'b00) ? model_addr(pm, sg, off, base) : 32'h0;
        @(negedge clk);
        req = 1'b0;
        report(tag, (fault_code == ef) && (valid == (ef == 2'b00)) && (lin_addr == ea),
               "{valid,fault,addr}",
               {lin_addr[28:0], valid, fault_code},
               {ea[28:0], (ef == 2'b00), ef});
        if (ef == 2'b00)
            report(tag, lin_addr == ea, "lin_addr", lin_addr, ea);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10 reset state
        report("R10", !valid && fault_code == 2'b00 && lin_addr == 32'h0, "reset",
               {lin_addr[28:0], valid, fault_code}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        report("R10", !valid && fault_code == 2'b00, "post-reset idle",
               {29'h0, valid, fault_code}, 32'h0);

        // R1 real mode
        xlate("R1", 0, 16'h1000, 32'h0000F000, 0, 0, 0, 0, 1, 0);
        report("R1", lin_addr == 32'h0001F000, "1000:F000", lin_addr, 32'h0001F000);
        xlate("R1", 0, 16'h1234, 32'h0000FFFF, 0, 0, 0, 0, 1, 0);
        report("R1", lin_addr == 32'h0002233F, "1234:FFFF", lin_addr, 32'h0002233F);
        xlate("R1", 0, 16'hFFFF, 32'hABCDFFFF, 0, 0, 0, 0, 1, 0);
        report("R1", lin_addr == 32'h0000FFEF, "20-bit wrap", lin_addr, 32'h0000FFEF);
        // R2 descriptor ignored in real mode
        xlate("R2", 0, 16'h2300, 32'h00000010, 32'hDEAD0000, 20'h0, 1, 2'd0, 0, 2'd3);
        report("R2", lin_addr == 32'h00023010, "real ignores desc", lin_addr, 32'h00023010);

        // R3 base + offset with wrap
        xlate("R3", 1, 0, 32'h00000020, 32'hFFFFFFF0, 20'hFFFFF, 1, 0, 1, 0);
        report("R3", lin_addr == 32'h00000010, "32-bit wrap", lin_addr, 32'h00000010);
        // R4 R6 byte limit edge
        xlate("R4", 1, 0, 32'h000001FF, 32'h10000000, 20'h001FF, 0, 0, 1, 0);
        report("R6", lin_addr == 32'h100001FF, "at limit", lin_addr, 32'h100001FF);
        xlate("R6", 1, 0, 32'h00000200, 32'h10000000, 20'h001FF, 0, 0, 1, 0);
        report("R6", fault_code == 2'b01, "past limit", {30'h0, fault_code}, 32'h1);
        xlate("R6", 1, 0, 32'h80000000, 32'h10000000, 20'hFFFFF, 0, 0, 1, 0);
        // R5 page granularity
        xlate("R5", 1, 0, 32'h001FFFFF, 32'h10000000, 20'h001FF, 1, 0, 1, 0);
        report("R5", lin_addr == 32'h101FFFFF, "scaled end", lin_addr, 32'h101FFFFF);
        xlate("R5", 1, 0, 32'h00200000, 32'h10000000, 20'h001FF, 1, 0, 1, 0);
        xlate("R5", 1, 0, 32'hFFFFFFFF, 32'h00000000, 20'hFFFFF, 1, 0, 1, 0);
        xlate("R5", 1, 0, 32'h00000FFF, 32'h00001000, 20'h00000, 1, 0, 1, 0);
        // R7 privilege
        xlate("R7", 1, 0, 32'h10, 32'h4000, 20'hFF, 0, 2'd1, 1, 2'd2);
        report("R7", fault_code == 2'b10, "rpl>dpl", {30'h0, fault_code}, 32'h2);
        xlate("R7", 1, 0, 32'h10, 32'h4000, 20'hFF, 0, 2'd1, 1, 2'd1);
        xlate("R7", 1, 0, 32'h10, 32'h4000, 20'hFF, 0, 2'd3, 1, 2'd0);
        // R8 absent and priority when rules collide
        xlate("R8", 1, 0, 32'h10, 32'h4000, 20'hFF, 0, 2'd3, 0, 2'd0);
        xlate("R8", 1, 0, 32'h1000, 32'h4000, 20'hFF, 0, 2'd0, 1, 2'd3);
        report("R8", fault_code == 2'b10, "priv over limit", {30'h0, fault_code}, 32'h2);
        xlate("R8", 1, 0, 32'h1000, 32'h4000, 20'hFF, 0, 2'd0, 0, 2'd3);
        report("R8", fault_code == 2'b11, "absent over all", {30'h0, fault_code}, 32'h3);

        // R11 idle, R9 single-cycle pulse
        @(negedge clk);
        report("R11", !valid && fault_code == 2'b00, "no request",
               {29'h0, valid, fault_code}, 32'h0);
        xlate("R9", 0, 16'h0001, 32'h1, 0, 0, 0, 0, 1, 0);
        @(negedge clk);
        report("R9", !valid, "valid one cycle", {31'h0, valid}, 32'h0);

        // random, back to back, offsets near the limit
        for (int i = 0; i < 400; i++) begin
            logic [19:0] lim;
            logic        g;
            logic [31:0] off, eff;
            lim = 20'($urandom);
            g   = 1'($urandom);
            eff = g ? {lim, 12'hFFF} : {12'h0, lim};
            case ($urandom % 3)
                0: off = eff;
                1: off = eff + 32'd1;
                default: off = $urandom;
            endcase
            xlate(((i % 2) == 0) ? "R3" : "R8", 1'($urandom % 4 != 0), 16'($urandom), off,
                  $urandom, lim, g, 2'($urandom), 1'($urandom % 5 != 0), 2'($urandom));
            if ((i % 17) == 0) begin
                @(negedge clk);
                report("R11", !valid && fault_code == 2'b00, "gap",
                       {29'h0, valid, fault_code}, 32'h0);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule